// File: doc/BRIEF.md
# RGB Pixel Bus Output Formatter

This block takes framebuffer pixel words, one per transfer, and turns each into the value driven on the parallel data lines of an RGB display panel. The source is either 16-bit colour (5/6/5 fields in the low half of the word) or 24-bit colour (one pixel per 32-bit word, top byte unused). Static configuration inputs select the panel data bus width, the source depth, an optional exchange of the red and blue fields, and an optional complement of the data lines.

Each accepted pixel is registered and appears on a 24-line output bus one clock later, together with a one-cycle valid strobe. Lines above the width the panel uses are held low. Truncation from 24-bit colour to a narrower panel keeps the low six bits of each component. The 8-bit panel bus needs several cycles per pixel and is not handled here. Selecting it raises an error flag, and pixels accepted in that mode leave the block as all-zero data.

Top module: `pixbus_fmt`

## Requirements
- R1: While reset is asserted, out_valid, out_data, cfg_err and in_ready are all 0. in_ready is 1 from the first clock edge after reset is released, and stays 1.
- R2: A pixel accepted at a clock edge (in_valid and in_ready both 1) shows on out_data with out_valid 1 after that edge, for exactly one cycle. In a cycle with no accepted pixel, out_valid is 0 after the next edge and out_data keeps its previous value.
- R3: With cfg_depth24 = 0 (16-bit source), word bits 15:11 (red), 10:5 (green) and 4:0 (blue) appear unchanged on out_data[15:0]. Word bits 31:16 have no effect, and out_data[23:16] is 0 for bus codes 0, 2 and 3.
- R4: With cfg_depth24 = 1 (24-bit source), red is taken from word bits 23:16, green from 15:8 and blue from 7:0, and word bits 31:24 have no effect. With bus code 3 (24-bit bus), all 24 bits pass to out_data unchanged in that layout.
- R5: With a 24-bit source and bus code 2 (18-bit bus), each component keeps only its low six bits and loses its two most significant bits. Red goes to out_data[17:12], green to [11:6] and blue to [5:0], and out_data[23:18] is 0.
- R6: With bus code 0 (16-bit bus), only out_data[15:0] carries data and out_data[23:16] is 0. For a 24-bit source this is the 18-bit packing of R5 with lines 17:16 removed.
- R7: With cfg_swap = 1, the red and blue fields exchange places on the output bus in every supported mode. Green keeps its position.
- R8: With cfg_invert = 1, every line inside the active width is complemented. The active width is 16 lines for a 16-bit source, 16 or 18 lines for a 24-bit source on a 16- or 18-bit bus, and 24 lines for a 24-bit source on the 24-bit bus. Lines above the active width stay 0.
- R9: Bus code 1 (8-bit bus) is unsupported for both source depths. cfg_err is 1 from the clock edge after the code is applied and returns to 0 one edge after it is removed. Pixels accepted with that code produce out_data = 0 with out_valid = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel word present |
| in_ready | output | 1 | Block can accept a pixel |
| in_word | input | 32 | Framebuffer pixel word |
| cfg_bus | input | 2 | Panel bus width code: 0 = 16, 1 = 8, 2 = 18, 3 = 24 lines |
| cfg_depth24 | input | 1 | 0 = 16-bit source, 1 = 24-bit source |
| cfg_swap | input | 1 | Exchange red and blue fields |
| cfg_invert | input | 1 | Complement active data lines |
| out_data | output | 24 | Panel data lines |
| out_valid | output | 1 | out_data holds a new pixel this cycle |
| cfg_err | output | 1 | Unsupported bus code selected |

## Verification
The assertions sample the configuration in the same cycle as the accepted pixel. They therefore assume that in_valid and the configuration inputs carry known values at each clock edge, and that only the settings present at acceptance define the output one cycle later. The stimulus drives every input on the falling edge and changes the configuration only while in_valid is low. Because of this, each check looks at a pixel formatted under a single setting.

// File: rtl/pixbus_pkg.sv
package pixbus_pkg;
    localparam int PIX_W  = 32;  // framebuffer word width
    localparam int OUT_W  = 24;  // panel data lines
    localparam int CW     = 8;   // full component width
    localparam int LO_W   = 6;   // component width after truncation
    localparam int AW_W   = $clog2(OUT_W + 1);

    typedef enum logic [1:0] {
        BUS16 = 2'd0,
        BUS8  = 2'd1,
        BUS18 = 2'd2,
        BUS24 = 2'd3
    } bus_code_e;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;
endpackage

// File: rtl/pixbus_unpack.sv
module pixbus_unpack
    import pixbus_pkg::*;
#(
    parameter int WORD_W = PIX_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              depth24,
    output rgb_t              px
);
    logic unused_top;
    assign unused_top = ^word[WORD_W-1:3*CW];

    always_comb begin
        if (depth24) begin
            px.r = word[3*CW-1:2*CW];
            px.g = word[2*CW-1:CW];
            px.b = word[CW-1:0];
        end else begin
            px.r = CW'(word[15:11]);
            px.g = CW'(word[10:5]);
            px.b = CW'(word[4:0]);
        end
    end
endmodule

// File: rtl/pixbus_pack.sv
module pixbus_pack
    import pixbus_pkg::*;
#(
    parameter int BUS_W = OUT_W
) (
    input  rgb_t             px,
    input  logic             depth24,
    input  bus_code_e        bus,
    input  logic             swap,
    output logic [BUS_W-1:0] raw,
    output logic [BUS_W-1:0] mask,
    output logic             err
);
    localparam int WW = $clog2(BUS_W + 1);

    logic [CW-1:0] hi_c, lo_c;
    logic [WW-1:0] width;

    always_comb begin
        hi_c  = swap ? px.b : px.r;
        lo_c  = swap ? px.r : px.b;
        err   = (bus == BUS8);
        raw   = '0;
        width = '0;
        if (!err) begin
            if (!depth24) begin
                raw   = BUS_W'({hi_c[4:0], px.g[5:0], lo_c[4:0]});
                width = WW'(16);
            end else if (bus == BUS24) begin
                raw   = BUS_W'({hi_c, px.g, lo_c});
                width = WW'(3 * CW);
            end else begin
                raw   = BUS_W'({hi_c[LO_W-1:0], px.g[LO_W-1:0], lo_c[LO_W-1:0]});
                width = (bus == BUS18) ? WW'(3 * LO_W) : WW'(16);
            end
        end
    end

    for (genvar gi = 0; gi < BUS_W; gi++) begin : g_mask
        assign mask[gi] = (WW'(gi) < width);
    end
endmodule

// File: rtl/pixbus_fmt.sv
module pixbus_fmt
    import pixbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_word,
    input  logic [1:0]        cfg_bus,
    input  logic              cfg_depth24,
    input  logic              cfg_swap,
    input  logic              cfg_invert,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_valid,
    output logic              cfg_err
);
    typedef struct packed {
        logic             rdy;
        logic             vld;
        logic             err;
        logic [OUT_W-1:0] data;
    } state_t;

    state_t    st_d, st_q;
    rgb_t      px;
    logic [OUT_W-1:0] raw, mask;
    logic      err_c;
    bus_code_e bus;

    assign bus = bus_code_e'(cfg_bus);

    pixbus_unpack #(.WORD_W(PIX_W)) u_unpack (
        .word    (in_word),
        .depth24 (cfg_depth24),
        .px      (px)
    );

    pixbus_pack #(.BUS_W(OUT_W)) u_pack (
        .px      (px),
        .depth24 (cfg_depth24),
        .bus     (bus),
        .swap    (cfg_swap),
        .raw     (raw),
        .mask    (mask),
        .err     (err_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.err = err_c;
        st_d.vld = in_valid & st_q.rdy;
        if (in_valid && st_q.rdy) begin
            st_d.data = (raw ^ (cfg_invert ? mask : '0)) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = st_q.rdy;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign cfg_err   = st_q.err;
endmodule

// File: rtl/pixbus_chk.sv
module pixbus_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [1:0]  cfg_bus,
    input logic        cfg_depth24,
    input logic [23:0] out_data,
    input logic        out_valid,
    input logic        cfg_err
);
    logic acc;
    assign acc = in_valid && in_ready;

    a_r2_valid_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid);

    a_r2_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(out_data));

    a_r3_upper_zero_16src: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cfg_depth24 && cfg_bus != 2'd1) |=> (out_data[23:16] == 8'd0));

    a_r5_upper_zero_18bus: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_bus == 2'd2) |=> (out_data[23:18] == 6'd0));

    a_r6_upper_zero_16bus: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_bus == 2'd0) |=> (out_data[23:16] == 8'd0));

    a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bus == 2'd1) |=> cfg_err);

    a_r9_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bus != 2'd1) |=> !cfg_err);

    a_r9_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_bus == 2'd1) |=> (out_data == 24'd0));

    a_r1_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);
endmodule

bind pixbus_fmt pixbus_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_bus     (cfg_bus),
    .cfg_depth24 (cfg_depth24),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .cfg_err     (cfg_err)
);

// File: tb/tb_pixbus_fmt.sv
`timescale 1ns/1ps
module tb_pixbus_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [1:0]  cfg_bus = 2'd0;
    logic        cfg_depth24 = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        cfg_invert = 1'b0;
    logic [23:0] out_data;
    logic        out_valid;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pixbus_fmt dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .cfg_bus(cfg_bus), .cfg_depth24(cfg_depth24),
        .cfg_swap(cfg_swap), .cfg_invert(cfg_invert), .out_data(out_data),
        .out_valid(out_valid), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] bus, input logic d24, input logic sw, input logic inv);
        @(negedge clk);
        cfg_bus = bus; cfg_depth24 = d24; cfg_swap = sw; cfg_invert = inv;
    endtask

    // one pixel; output checked one edge later
    task automatic send(input string req, input logic [31:0] w, input logic [23:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 24'(out_valid), 24'd1);
        check({req, " data"}, out_data, exp);
    endtask

    task automatic t_reset;
        #1;
        check("R1 valid", 24'(out_valid), 24'd0);
        check("R1 data", out_data, 24'd0);
        check("R1 err", 24'(cfg_err), 24'd0);
        check("R1 ready", 24'(in_ready), 24'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after", 24'(in_ready), 24'd1);
    endtask

    task automatic t_handshake;
        setup(2'd3, 1'b1, 1'b0, 1'b0);
        send("R2 first", 32'h00ABCDEF, 24'hABCDEF);
        @(negedge clk);
        check("R2 idle valid", 24'(out_valid), 24'd0);
        check("R2 hold data", out_data, 24'hABCDEF);
        in_valid = 1'b1; in_word = 32'h00111111;
        @(negedge clk);
        in_word = 32'h00222222;
        check("R2 b2b 1", out_data, 24'h111111);
        check("R2 b2b v1", 24'(out_valid), 24'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b 2", out_data, 24'h222222);
        check("R2 b2b v2", 24'(out_valid), 24'd1);
    endtask

    task automatic t_src16;
        setup(2'd0, 1'b0, 1'b0, 1'b0);
        send("R3 bus16 upper ignored", 32'hABCDF81F, 24'h00F81F);
        setup(2'd3, 1'b0, 1'b0, 1'b0);
        send("R3 bus24", 32'hFFFF1234, 24'h001234);
        setup(2'd2, 1'b0, 1'b0, 1'b0);
        send("R3 bus18", 32'h00001234, 24'h001234);
    endtask

    task automatic t_src24;
        setup(2'd3, 1'b1, 1'b0, 1'b0);
        send("R4 pass", 32'hAA123456, 24'h123456);
        setup(2'd2, 1'b1, 1'b0, 1'b0);
        send("R5 trunc", 32'h00123456, 24'h012D16);
        send("R5 full", 32'hFFFFFFFF, 24'h03FFFF);
        setup(2'd0, 1'b1, 1'b0, 1'b0);
        send("R6 bus16", 32'h00123456, 24'h002D16);
    endtask

    task automatic t_swap;
        setup(2'd0, 1'b0, 1'b1, 1'b0);
        send("R7 565 red", 32'h0000F800, 24'h00001F);
        send("R7 565 green", 32'h000007E0, 24'h0007E0);
        setup(2'd3, 1'b1, 1'b1, 1'b0);
        send("R7 888", 32'h00123456, 24'h563412);
        setup(2'd2, 1'b1, 1'b1, 1'b0);
        send("R7 666", 32'h00123456, 24'h016D12);
    endtask

    task automatic t_invert;
        setup(2'd3, 1'b0, 1'b0, 1'b1);
        send("R8 565", 32'h00001234, 24'h00EDCB);
        setup(2'd3, 1'b1, 1'b0, 1'b1);
        send("R8 888", 32'h00123456, 24'hEDCBA9);
        setup(2'd2, 1'b1, 1'b0, 1'b1);
        send("R8 666", 32'h00123456, 24'h02D2E9);
        setup(2'd0, 1'b1, 1'b0, 1'b1);
        send("R8 bus16", 32'h00123456, 24'h00D2E9);
    endtask

    task automatic t_err;
        setup(2'd1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 err 24src", 24'(cfg_err), 24'd1);
        send("R9 zero 24src", 32'h00FFFFFF, 24'h000000);
        setup(2'd1, 1'b0, 1'b0, 1'b1);
        send("R9 zero 16src", 32'h0000FFFF, 24'h000000);
        check("R9 err 16src", 24'(cfg_err), 24'd1);
        setup(2'd3, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 err clear", 24'(cfg_err), 24'd0);
    endtask

    initial begin
        t_reset();
        t_handshake();
        t_src16();
        t_src24();
        t_swap();
        t_invert();
        t_err();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule